// File: doc/BRIEF.md
# Video Active/Blanking Pixel Steering

This block moves a parallel pixel stream across a modelled video link and decides, pixel by pixel, what each side carries. The transmit half looks at the data-enable input. When it is high it sends the colour and user bits unchanged. When it is low it sends the two sync levels instead, together with any side-channel bits that sit at chosen colour or user bit positions. The link between the halves is a registered payload word plus a header that holds a video/blanking flag and the two sync levels.

The receive half rebuilds the parallel outputs. During active video it passes the colour and user bits through and holds both sync outputs at their last blanking values. During blanking it updates the sync outputs and forces every non-side-channel bit low. It also clears the side-channel bits on the first and last pixel of each blanking period, so it keeps one pixel of lookahead. A static input turns side-channel transport on or off. A monitor on the transmit data-enable raises a sticky flag when a high or low period is shorter than the legal minimum.

The pixel word is ordered {user[1:0], red, green, blue}, with blue in the low bits. The default colour depth is 10 bits per channel. With that depth, the side-channel positions are bit 0 (blue[0]), bit 10 (green[0]), bit 20 (red[0]) and bit 30 (user[0]).

Top module: `vid_blank_mux`

## Requirements
- R1: A pixel presented with tx_de high appears on the receive outputs three clock edges after it is sampled, with rx_de high and red, green, blue and user bits equal to the transmitted ones.
- R2: A pixel presented with tx_de low appears three clock edges after sampling with rx_de low and rx_hsync/rx_vsync equal to that pixel's tx_hsync/tx_vsync.
- R3: While rx_de is high, rx_hsync and rx_vsync keep the values of the last blanking pixel, and tx_hsync/tx_vsync driven during active video have no effect on them.
- R4: While rx_de is low, every output bit outside the side-channel positions (bits 0, 10, 20 and 30 of {user, red, green, blue}) is 0.
- R5: With ctl_en high, a blanking pixel that is neither the first nor the last of its blanking period carries the transmitted values of the side-channel bits.
- R6: The first blanking pixel after active video and the last blanking pixel before active video have all side-channel bits at 0, so a two-pixel blanking period carries none.
- R7: With ctl_en low, all receive colour and user outputs are 0 throughout blanking.
- R8: de_err is set when a period of tx_de high or tx_de low that is bounded by two edges lasts fewer than 2 cycles. Periods of 2 or more cycles never set it, and once set it stays set until reset.
- R9: During and after reset, all outputs are 0, rx_de is low and the held sync levels are 0 until the first blanking pixel arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_en | input | 1 | Static enable for side-channel transport in blanking |
| tx_de | input | 1 | Transmit data enable: high for active video |
| tx_hsync | input | 1 | Transmit horizontal sync level |
| tx_vsync | input | 1 | Transmit vertical sync level |
| tx_r | input | COLOR_BITS | Transmit red |
| tx_g | input | COLOR_BITS | Transmit green |
| tx_b | input | COLOR_BITS | Transmit blue |
| tx_cont | input | 2 | Transmit user bits |
| rx_de | output | 1 | Rebuilt data enable |
| rx_hsync | output | 1 | Rebuilt horizontal sync |
| rx_vsync | output | 1 | Rebuilt vertical sync |
| rx_r | output | COLOR_BITS | Rebuilt red |
| rx_g | output | COLOR_BITS | Rebuilt green |
| rx_b | output | COLOR_BITS | Rebuilt blue |
| rx_cont | output | 2 | Rebuilt user bits |
| de_err | output | 1 | Sticky flag for a too-short data-enable period |

## Verification
The main stream mixes blanking periods of 2, 3, 4 and 5 pixels with video periods of 2 to 4 pixels, using pixel words that differ in every field. The 2-pixel blanking period isolates the first/last clearing of R6, while the longer periods show side data surviving on the interior pixels only. The same stream is then run with side-channel transport off, to tell the R7 forcing apart from the position rules. Sync inputs keep toggling during active video and a run starts with video straight after reset, which separates a genuine hold from pass-through and from stale state. A single-pixel video pulse sets the error flag, further legal traffic shows that it stays set, and a reset clears it.

// File: rtl/vbm_pkg.sv
package vbm_pkg;
   localparam int CONT_W = 2;

   typedef struct packed {
      logic vid;
      logic vsync;
      logic hsync;
   } lnk_hdr_t;

   function automatic int pix_width(input int color_bits);
      return 3 * color_bits + CONT_W;
   endfunction
endpackage

// File: rtl/vbm_tx.sv
module vbm_tx
   import vbm_pkg::*;
#(
   parameter int               PIX_W    = 32,
   parameter logic [PIX_W-1:0] CTL_MASK = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             de,
   input  logic             hsync,
   input  logic             vsync,
   input  logic [PIX_W-1:0] pix,
   output lnk_hdr_t         hdr_q,
   output logic [PIX_W-1:0] pay_q
);
   // Active video carries the full word; blanking carries only the sync
   // levels in the header and the side-channel positions in the payload.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hdr_q <= '0;
         pay_q <= '0;
      end else if (de) begin
         hdr_q <= '{vid: 1'b1, vsync: 1'b0, hsync: 1'b0};
         pay_q <= pix;
      end else begin
         hdr_q <= '{vid: 1'b0, vsync: vsync, hsync: hsync};
         pay_q <= pix & CTL_MASK;
      end
   end
endmodule

// File: rtl/vbm_rx.sv
module vbm_rx
   import vbm_pkg::*;
#(
   parameter int               PIX_W    = 32,
   parameter logic [PIX_W-1:0] CTL_MASK = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_en,
   input  lnk_hdr_t         lnk_hdr,
   input  logic [PIX_W-1:0] lnk_pay,
   output logic             out_de,
   output logic             out_hsync,
   output logic             out_vsync,
   output logic [PIX_W-1:0] out_pix
);
   lnk_hdr_t         cur_hdr;
   logic [PIX_W-1:0] cur_pay;
   logic             prev_vid;
   logic             edge_first;
   logic             edge_last;
   logic             side_ok;
   logic [PIX_W-1:0] blank_pix;

   // One pixel of lookahead: the link word is the next pixel, cur_* is the
   // pixel about to be emitted, prev_vid the type of the one before it.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_hdr  <= '0;
         cur_pay  <= '0;
         prev_vid <= 1'b0;
      end else begin
         cur_hdr  <= lnk_hdr;
         cur_pay  <= lnk_pay;
         prev_vid <= cur_hdr.vid;
      end
   end

   assign edge_first = !cur_hdr.vid && prev_vid;
   assign edge_last  = !cur_hdr.vid && lnk_hdr.vid;
   assign side_ok    = ctl_en && !edge_first && !edge_last;

   // Blanking word: side-channel positions gated, all others tied low.
   for (genvar i = 0; i < PIX_W; i++) begin : g_bit
      if (CTL_MASK[i]) begin : g_ctl
         assign blank_pix[i] = cur_pay[i] & side_ok;
      end else begin : g_zero
         assign blank_pix[i] = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_de    <= 1'b0;
         out_hsync <= 1'b0;
         out_vsync <= 1'b0;
         out_pix   <= '0;
      end else if (cur_hdr.vid) begin
         out_de  <= 1'b1;
         out_pix <= cur_pay;
      end else begin
         out_de    <= 1'b0;
         out_hsync <= cur_hdr.hsync;
         out_vsync <= cur_hdr.vsync;
         out_pix   <= blank_pix;
      end
   end
endmodule

// File: rtl/vbm_de_mon.sv
module vbm_de_mon #(
   parameter int MIN_PERIOD = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic de,
   output logic err
);
   localparam int CW = $clog2(MIN_PERIOD + 1);
   localparam logic [CW-1:0] SAT = CW'(MIN_PERIOD);

   logic          de_prev;
   logic          started;
   logic [CW-1:0] run_q;
   logic          toggle;

   assign toggle = de != de_prev;

   // run_q is the saturated length of the run that de_prev belongs to; only
   // runs opened by an observed edge are judged.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         de_prev <= 1'b0;
         started <= 1'b0;
         run_q   <= '0;
         err     <= 1'b0;
      end else begin
         de_prev <= de;
         if (toggle) begin
            if (started && run_q < SAT) err <= 1'b1;
            started <= 1'b1;
            run_q   <= CW'(1);
         end else if (run_q < SAT) begin
            run_q <= run_q + CW'(1);
         end
      end
   end
endmodule

// File: rtl/vid_blank_mux.sv
module vid_blank_mux
   import vbm_pkg::*;
#(
   parameter int          COLOR_BITS = 10,
   parameter logic [31:0] CTL_MASK   = 32'h4010_0401,
   parameter int          MIN_PERIOD = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ctl_en,
   input  logic                  tx_de,
   input  logic                  tx_hsync,
   input  logic                  tx_vsync,
   input  logic [COLOR_BITS-1:0] tx_r,
   input  logic [COLOR_BITS-1:0] tx_g,
   input  logic [COLOR_BITS-1:0] tx_b,
   input  logic [CONT_W-1:0]     tx_cont,
   output logic                  rx_de,
   output logic                  rx_hsync,
   output logic                  rx_vsync,
   output logic [COLOR_BITS-1:0] rx_r,
   output logic [COLOR_BITS-1:0] rx_g,
   output logic [COLOR_BITS-1:0] rx_b,
   output logic [CONT_W-1:0]     rx_cont,
   output logic                  de_err
);
   localparam int               PIX_W    = pix_width(COLOR_BITS);
   localparam logic [PIX_W-1:0] LOC_MASK = CTL_MASK[PIX_W-1:0];

   if (COLOR_BITS != 8 && COLOR_BITS != 10) begin : g_bad_depth
      $error("COLOR_BITS must be 8 or 10");
   end
   if ((CTL_MASK >> PIX_W) != 32'd0) begin : g_bad_mask
      $error("CTL_MASK has bits above the pixel word");
   end
   if (MIN_PERIOD < 1) begin : g_bad_period
      $error("MIN_PERIOD must be at least 1");
   end

   logic [PIX_W-1:0] tx_pix;
   logic [PIX_W-1:0] rx_pix;
   lnk_hdr_t         lnk_hdr;
   logic [PIX_W-1:0] lnk_pay;

   assign tx_pix = {tx_cont, tx_r, tx_g, tx_b};
   assign {rx_cont, rx_r, rx_g, rx_b} = rx_pix;

   vbm_tx #(.PIX_W(PIX_W), .CTL_MASK(LOC_MASK)) u_tx (
      .clk   (clk),
      .rst_n (rst_n),
      .de    (tx_de),
      .hsync (tx_hsync),
      .vsync (tx_vsync),
      .pix   (tx_pix),
      .hdr_q (lnk_hdr),
      .pay_q (lnk_pay)
   );

   vbm_rx #(.PIX_W(PIX_W), .CTL_MASK(LOC_MASK)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_en    (ctl_en),
      .lnk_hdr   (lnk_hdr),
      .lnk_pay   (lnk_pay),
      .out_de    (rx_de),
      .out_hsync (rx_hsync),
      .out_vsync (rx_vsync),
      .out_pix   (rx_pix)
   );

   vbm_de_mon #(.MIN_PERIOD(MIN_PERIOD)) u_mon (
      .clk   (clk),
      .rst_n (rst_n),
      .de    (tx_de),
      .err   (de_err)
   );
endmodule

// File: rtl/vbm_chk.sv
module vbm_chk #(
   parameter int               PIX_W = 32,
   parameter logic [PIX_W-1:0] MASK  = '0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ctl_en,
   input logic             tx_de,
   input logic             tx_hsync,
   input logic             tx_vsync,
   input logic             rx_de,
   input logic             rx_hsync,
   input logic             rx_vsync,
   input logic [PIX_W-1:0] rx_pix,
   input logic             de_err
);
   logic [1:0] warm_q;
   logic       warm;
   logic       in_rst_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              warm_q <= '0;
      else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
   end
   assign warm = warm_q == 2'd3;

   always_ff @(posedge clk) in_rst_q <= !rst_n;

   AST_DE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      warm |-> rx_de == $past(tx_de, 3)) else $error("de latency"); // R1
   AST_SYNC_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      warm && !rx_de |-> rx_hsync == $past(tx_hsync, 3) && rx_vsync == $past(tx_vsync, 3))
      else $error("sync follow"); // R2
   AST_SYNC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      warm && rx_de |-> $stable(rx_hsync) && $stable(rx_vsync)) else $error("sync hold"); // R3
   AST_BLANK_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_de |-> (rx_pix & ~MASK) == '0) else $error("blank masked"); // R4
   AST_FIRST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      warm && !rx_de && $past(rx_de) |-> (rx_pix & MASK) == '0) else $error("first clear"); // R6
   AST_CTL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_en && !rx_de |-> rx_pix == '0) else $error("ctl off"); // R7
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      de_err |=> de_err) else $error("err sticky"); // R8

   always @(posedge clk) begin
      if (!rst_n && in_rst_q) begin
         AST_RST_CLEAR: assert (!rx_de && !rx_hsync && !rx_vsync && rx_pix == '0 && !de_err)
            else $error("reset clear"); // R9
      end
   end
endmodule

bind vid_blank_mux vbm_chk #(.PIX_W(PIX_W), .MASK(LOC_MASK)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ctl_en   (ctl_en),
   .tx_de    (tx_de),
   .tx_hsync (tx_hsync),
   .tx_vsync (tx_vsync),
   .rx_de    (rx_de),
   .rx_hsync (rx_hsync),
   .rx_vsync (rx_vsync),
   .rx_pix   (rx_pix),
   .de_err   (de_err)
);

// File: tb/vid_blank_mux_tb.sv
`timescale 1ns/1ps
module vid_blank_mux_tb;
   localparam int          CB   = 10;
   localparam logic [31:0] MASK = 32'h4010_0401;
   localparam int          MAXN = 256;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ctl_en = 1'b0;
   logic          tx_de = 1'b0, tx_hsync = 1'b0, tx_vsync = 1'b0;
   logic [CB-1:0] tx_r = '0, tx_g = '0, tx_b = '0;
   logic [1:0]    tx_cont = '0;
   logic          rx_de, rx_hsync, rx_vsync, de_err;
   logic [CB-1:0] rx_r, rx_g, rx_b;
   logic [1:0]    rx_cont;

   always #2.5 clk = ~clk;

   vid_blank_mux u_dut (
      .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en),
      .tx_de(tx_de), .tx_hsync(tx_hsync), .tx_vsync(tx_vsync),
      .tx_r(tx_r), .tx_g(tx_g), .tx_b(tx_b), .tx_cont(tx_cont),
      .rx_de(rx_de), .rx_hsync(rx_hsync), .rx_vsync(rx_vsync),
      .rx_r(rx_r), .rx_g(rx_g), .rx_b(rx_b), .rx_cont(rx_cont),
      .de_err(de_err)
   );

   int          n_tests = 0;
   int          n_fail  = 0;
   bit          done    = 1'b0;
   logic        s_de [MAXN];
   logic        s_hs [MAXN];
   logic        s_vs [MAXN];
   logic [31:0] s_pix[MAXN];
   int          s_len = 0;

   function automatic logic [31:0] rx_word();
      return {rx_cont, rx_r, rx_g, rx_b};
   endfunction

   task automatic chk(input string req, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic drive(input logic de, input logic hs, input logic vs, input logic [31:0] p);
      tx_de = de; tx_hsync = hs; tx_vsync = vs;
      {tx_cont, tx_r, tx_g, tx_b} = p;
   endtask

   task automatic do_reset(input logic en);
      @(negedge clk);
      rst_n = 1'b0; ctl_en = en;
      drive(1'b0, 1'b0, 1'b0, '0);
      repeat (3) @(negedge clk);
      chk("R9", "rx_de in reset", 32'(rx_de), 32'd0);
      chk("R9", "sync in reset", {30'd0, rx_vsync, rx_hsync}, 32'd0);
      chk("R9", "word in reset", rx_word(), 32'd0);
      chk("R9", "de_err in reset", 32'(de_err), 32'd0);
      rst_n = 1'b1;
      s_len = 0;
   endtask

   task automatic add_run(input logic de, input int len, input int seed);
      for (int k = 0; k < len; k++) begin
         logic [31:0] h;
         h = (32'(s_len + seed) * 32'h9E37_79B1) ^ 32'h5A5A_C3C3 ^ 32'(seed << 7);
         s_de[s_len]  = de;
         s_pix[s_len] = h;
         s_hs[s_len]  = h[31] ^ h[3];
         s_vs[s_len]  = h[30] ^ h[5];
         s_len++;
      end
   endtask

   // Drives the stored stream and checks pixel j three negedges later.
   task automatic run_seq();
      logic held_h = 1'b0, held_v = 1'b0;
      for (int i = 0; i < s_len + 3; i++) begin
         if (i >= 3) begin
            int          j;
            logic        nx, first, last;
            logic [31:0] act, exp_ctl;
            j     = i - 3;
            nx    = (j + 1 < s_len) ? s_de[j+1] : s_de[j];
            first = (j > 0) && s_de[j-1];
            last  = nx;
            act   = rx_word();
            if (s_de[j]) begin
               chk("R1", "rx_de video", 32'(rx_de), 32'd1);
               chk("R1", "video word", act, s_pix[j]);
               chk("R3", "held sync", {30'd0, rx_vsync, rx_hsync}, {30'd0, held_v, held_h});
            end else begin
               held_h = s_hs[j]; held_v = s_vs[j];
               chk("R2", "rx_de blank", 32'(rx_de), 32'd0);
               chk("R2", "blank sync", {30'd0, rx_vsync, rx_hsync}, {30'd0, held_v, held_h});
               chk("R4", "non-side bits", act & ~MASK, 32'd0);
               if (!ctl_en) begin
                  chk("R7", "side bits off", act & MASK, 32'd0);
               end else if (first || last) begin
                  chk("R6", "side bits at edge", act & MASK, 32'd0);
               end else begin
                  exp_ctl = s_pix[j] & MASK;
                  chk("R5", "side bits", act & MASK, exp_ctl);
               end
            end
         end
         if (i < s_len) drive(s_de[i], s_hs[i], s_vs[i], s_pix[i]);
         @(negedge clk);
      end
   endtask

   task automatic build_mixed(input int seed);
      add_run(1'b0, 3, seed); add_run(1'b1, 4, seed);
      add_run(1'b0, 2, seed); add_run(1'b1, 2, seed);
      add_run(1'b0, 5, seed); add_run(1'b1, 3, seed);
      add_run(1'b0, 4, seed); add_run(1'b1, 2, seed);
      add_run(1'b0, 3, seed);
   endtask

   task automatic t_reset();
      do_reset(1'b1);
   endtask

   task automatic t_side_on();
      do_reset(1'b1);
      build_mixed(11);
      run_seq();
      chk("R8", "no error on legal periods", 32'(de_err), 32'd0);
   endtask

   task automatic t_side_off();
      do_reset(1'b0);
      build_mixed(29);
      run_seq();
      chk("R8", "no error, side off", 32'(de_err), 32'd0);
   endtask

   task automatic t_video_first();
      do_reset(1'b1);
      add_run(1'b1, 4, 53); add_run(1'b0, 3, 53); add_run(1'b1, 3, 61);
      run_seq();
   endtask

   task automatic t_short_period();
      do_reset(1'b1);
      add_run(1'b0, 3, 71); add_run(1'b1, 1, 71); add_run(1'b0, 3, 71);
      run_seq();
      chk("R8", "error after 1-cycle video", 32'(de_err), 32'd1);
      s_len = 0;
      add_run(1'b1, 3, 83); add_run(1'b0, 3, 83);
      run_seq();
      chk("R8", "error stays set", 32'(de_err), 32'd1);
      do_reset(1'b1);
      @(negedge clk);
      chk("R8", "error cleared by reset", 32'(de_err), 32'd0);
   endtask

   initial begin
      t_reset();
      t_side_on();
      t_side_off();
      t_video_first();
      t_short_period();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule